// File: doc/BRIEF.md
# Single-Bus Register Transfer Adder

This block is a small datapath in which a register file, a combinational adder and two holding registers (an operand latch Y and a result latch Z) all hang off one shared 32-bit bus. A request names a destination register and two source registers. A sequencer breaks that request into three clocked transfers: the second source goes to Y, then the first source plus Y goes to Z, then Z goes to the destination. At most one source drives the bus in any step.

The bus is a multiplexer selected by one-hot gate-out enables; there is no tri-state modelling. A caller pulses `start` with the three indices and waits for `done`. A combinational debug port reads any register at any time. After reset each register holds its own index as its value, which gives the adds a non-trivial starting state.

Top module: `xfer_add_top`

## Requirements
- R1: While reset is held and right after its release, `busy` and `done` are 0 and register i reads back the value i on the debug port, for every i.
- R2: A request with indices (d, a, b) leaves register d holding the old value of register a plus the old value of register b.
- R3: If `start` is sampled high at clock edge k while idle, `busy` is 1 from edge k until edge k+4, and `done` is 1 only between edges k+3 and k+4.
- R4: At most one of the two gate-out enables (register file, Z) is active in any cycle.
- R5: The steps run in a fixed order: strobe Y with the register file on the bus, then strobe Z with the register file on the bus, then strobe the destination with Z on the bus.
- R6: `start` and index changes while `busy` is 1 have no effect: the running add completes with its original indices and no extra add follows.
- R7: Any of d, a and b may be equal, including all three; the result still follows R2.
- R8: A request changes no register other than register d.
- R9: The sum is taken modulo 2^32; a carry out of bit 31 is dropped.
- R10: `dbgData` shows the register selected by `dbgIdx` combinationally, at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| dstIdx | input | 5 | Destination register index |
| srcAIdx | input | 5 | First source register index |
| srcBIdx | input | 5 | Second source register index |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| dbgIdx | input | 5 | Debug read index |
| dbgData | output | 32 | Contents of the register selected by dbgIdx |

## Verification
Random requests with independent indices over a model of all 32 registers show that the right operands reach the adder and that only the destination changes. Directed cases with all indices equal, destination equal to one source, and sources equal but destination different tell apart a design that latches operands correctly from one that reads a register after it has been overwritten. A chain of self-doublings pushes the values past 2^32 to expose carry handling. Requests issued with `start` and the indices toggling during `busy` separate a design that latches indices once from one that re-reads them or restarts.

// File: rtl/xfer_add_pkg.sv
package xfer_add_pkg;

  typedef enum logic [1:0] {
    SEL_A = 2'd0,
    SEL_B = 2'd1,
    SEL_D = 2'd2
  } idx_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOADY = 3'd1,
    ST_SUMZ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIN   = 3'd4
  } seq_state_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic     latchIdx;
    logic     gateReg;
    logic     gateZ;
    logic     strobeY;
    logic     strobeZ;
    logic     strobeReg;
    idx_sel_e idxSel;
  } xfer_ctrl_t;

endpackage

// File: rtl/xfer_add_adder.sv
module xfer_add_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opY,
  input  logic [DATA_W-1:0] opBus,
  output logic [DATA_W-1:0] sum
);
  // Purely combinational; carry out of the top bit is dropped
  assign sum = opY + opBus;
endmodule

// File: rtl/xfer_add_ctrl.sv
module xfer_add_ctrl
  import xfer_add_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output xfer_ctrl_t ctrl,
  output logic       busy,
  output logic       done
);
  seq_state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    ctrl.idxSel = SEL_A;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.latchIdx = 1'b1;
          stateNxt      = ST_LOADY;
        end
      end
      ST_LOADY: begin
        ctrl.gateReg = 1'b1;
        ctrl.idxSel  = SEL_B;
        ctrl.strobeY = 1'b1;
        stateNxt     = ST_SUMZ;
      end
      ST_SUMZ: begin
        ctrl.gateReg = 1'b1;
        ctrl.idxSel  = SEL_A;
        ctrl.strobeZ = 1'b1;
        stateNxt     = ST_WRITE;
      end
      ST_WRITE: begin
        ctrl.gateZ     = 1'b1;
        ctrl.idxSel    = SEL_D;
        ctrl.strobeReg = 1'b1;
        stateNxt       = ST_FIN;
      end
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/xfer_add_datapath.sv
module xfer_add_datapath
  import xfer_add_pkg::*;
#(
  parameter  int DATA_W   = 32,
  parameter  int NUM_REGS = 32,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  xfer_ctrl_t        ctrl,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [IDX_W-1:0]  srcBIdx,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0] dbgData
);
  localparam int NUM_SRC = 2;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] yReg, zReg, bus, sum;
  logic [IDX_W-1:0]  dLat, aLat, bLat, selIdx;
  logic [NUM_SRC-1:0] busSel;
  logic [DATA_W-1:0]  srcVal [NUM_SRC];

  // Indices are captured once when the request is accepted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dLat <= '0;
      aLat <= '0;
      bLat <= '0;
    end else if (ctrl.latchIdx) begin
      dLat <= dstIdx;
      aLat <= srcAIdx;
      bLat <= srcBIdx;
    end
  end

  always_comb begin
    unique case (ctrl.idxSel)
      SEL_B:   selIdx = bLat;
      SEL_D:   selIdx = dLat;
      default: selIdx = aLat;
    endcase
  end

  // One-hot selected bus: bit 0 register file, bit 1 Z
  assign busSel    = {ctrl.gateZ, ctrl.gateReg};
  assign srcVal[0] = regs[selIdx];
  assign srcVal[1] = zReg;

  always_comb begin
    bus = '0;
    for (int s = 0; s < NUM_SRC; s++)
      bus = bus | ({DATA_W{busSel[s]}} & srcVal[s]);
  end

  xfer_add_adder #(.DATA_W(DATA_W)) u_adder (
    .opY  (yReg),
    .opBus(bus),
    .sum  (sum)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yReg <= '0;
      zReg <= '0;
    end else begin
      if (ctrl.strobeY) yReg <= bus;
      if (ctrl.strobeZ) zReg <= sum;
    end
  end

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regs[r] <= DATA_W'(r);
        else if (ctrl.strobeReg && (selIdx == IDX_W'(r)))
          regs[r] <= bus;
      end
    end
  endgenerate

  assign dbgData = regs[dbgIdx];
endmodule

// File: rtl/xfer_add_top.sv
module xfer_add_top
  import xfer_add_pkg::*;
#(
  parameter  int DATA_W   = 32,
  parameter  int NUM_REGS = 32,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [IDX_W-1:0]  srcBIdx,
  output logic              busy,
  output logic              done,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0] dbgData
);
  xfer_ctrl_t ctrlBus;

  xfer_add_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrlBus),
    .busy (busy),
    .done (done)
  );

  xfer_add_datapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrlBus),
    .dstIdx (dstIdx),
    .srcAIdx(srcAIdx),
    .srcBIdx(srcBIdx),
    .dbgIdx (dbgIdx),
    .dbgData(dbgData)
  );
endmodule

// File: rtl/xfer_add_chk.sv
module xfer_add_chk
  import xfer_add_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input xfer_ctrl_t ctrl
);
  a_r4_single_driver: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctrl.gateReg, ctrl.gateZ}) <= 1);

  a_r5_y_then_z: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.strobeY |=> (ctrl.strobeZ && ctrl.gateReg && !ctrl.gateZ));

  a_r5_z_then_write: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.strobeZ |=> (ctrl.strobeReg && ctrl.gateZ && !ctrl.gateReg));

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(ctrl.strobeReg));

  a_r3_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  a_r6_no_latch_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctrl.latchIdx);
endmodule

bind xfer_add_top xfer_add_chk u_chk (
  .clk  (clk),
  .rstN (rstN),
  .start(start),
  .busy (busy),
  .done (done),
  .ctrl (ctrlBus)
);

// File: tb/sim_xfer_add_top.sv
`timescale 1ns/1ps
module sim_xfer_add_top;
  localparam int NR = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  dstIdx = '0, srcAIdx = '0, srcBIdx = '0, dbgIdx = '0;
  logic        busy, done;
  logic [31:0] dbgData;

  logic [31:0] model [NR];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xfer_add_top u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .dstIdx(dstIdx), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .busy(busy), .done(done), .dbgIdx(dbgIdx), .dbgData(dbgData)
  );

  function automatic logic [31:0] expSum(logic [31:0] x, logic [31:0] y);
    return x + y;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Read every register through the debug port; dst gets reqTag
  task automatic scanRegs(input int dst, input string reqTag);
    for (int i = 0; i < NR; i++) begin
      dbgIdx = 5'(i);
      #0.1;
      if (i == dst) check(dbgData === model[i], reqTag, dbgData, model[i]);
      else check(dbgData === model[i], "R8 untouched reg", dbgData, model[i]);
    end
  endtask

  task automatic doAdd(input int d, input int a, input int b,
                       input bit noise, input string reqTag);
    logic [31:0] want;
    @(negedge clk);
    dstIdx = 5'(d); srcAIdx = 5'(a); srcBIdx = 5'(b);
    start = 1'b1;
    want = expSum(model[a], model[b]);
    for (int cyc = 1; cyc <= 5; cyc++) begin
      @(negedge clk);
      if (noise && cyc < 4) begin
        start = 1'b1;
        dstIdx = 5'($urandom); srcAIdx = 5'($urandom); srcBIdx = 5'($urandom);
      end else begin
        start = 1'b0;
      end
      if (cyc <= 4)
        check(busy === 1'b1, "R3 busy during request", {31'd0, busy}, 32'd1);
      else
        check(busy === 1'b0, noise ? "R6 no restart" : "R3 busy drops",
              {31'd0, busy}, 32'd0);
      check(done === (cyc == 4), "R3 done timing", {31'd0, done},
            {31'd0, cyc == 4});
    end
    model[d] = want;
    scanRegs(d, reqTag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NR; i++) model[i] = 32'(i);
    #1;
    check(busy === 1'b0 && done === 1'b0, "R1 reset outputs",
          {30'd0, busy, done}, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 after release",
          {30'd0, busy, done}, 32'd0);
    scanRegs(0, "R1 reset value");

    // R10: debug port follows dbgIdx without a clock edge
    dbgIdx = 5'd17; #0.1;
    check(dbgData === 32'd17, "R10 comb read", dbgData, 32'd17);
    dbgIdx = 5'd9;  #0.1;
    check(dbgData === 32'd9, "R10 comb read", dbgData, 32'd9);

    // Directed R2 / R7 corners
    doAdd(4, 7, 11, 0, "R2 basic add");
    doAdd(6, 6, 6, 0, "R7 all equal");
    doAdd(8, 8, 3, 0, "R7 dst equals srcA");
    doAdd(9, 2, 9, 0, "R7 dst equals srcB");
    doAdd(12, 5, 5, 0, "R7 equal sources");

    // R6: start and indices toggle while busy
    doAdd(13, 4, 6, 1, "R6 indices held");
    doAdd(14, 13, 1, 1, "R6 indices held");

    // R9: repeated doubling runs past 2^32
    for (int k = 0; k < 34; k++) doAdd(3, 3, 3, 0, "R9 wrap");
    check(model[3] === 32'd0, "R9 model wrapped", model[3], 32'd0);
    doAdd(20, 31, 30, 0, "R2 basic add");
    for (int k = 0; k < 6; k++) doAdd(20, 20, 20, 0, "R9 wrap");

    // Random requests
    for (int n = 0; n < 300; n++) begin
      doAdd(int'($urandom % NR), int'($urandom % NR), int'($urandom % NR),
            bit'($urandom % 4 == 0), "R2 random add");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule